// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Block

This block keeps the interrupt flags of a six-channel DMA engine. A channel's transfer engine reports four kinds of event with single-cycle pulses: block end, half transfer, transfer complete and transfer error. Each event sets its own sticky flag. Each channel also has a summary ("global") flag that rises whenever any of the channel's events fires. Software reads all thirty flags from one status word. It drops flags by writing ones to a separate clear word, which never holds state of its own.

The global flag and the four event flags are coupled in both directions. Clearing any one event flag also drops the channel's global flag, even while other event flags of that channel remain set. Clearing the global flag wipes all four event flags of the channel together. Each channel's global flag is tracked by a two-state machine. `CH_QUIET` means the global flag is 0 and `CH_FLAGGED` means it is 1. Transition RAISE goes from `CH_QUIET` to `CH_FLAGGED` on any event pulse of the channel. Transition DROP goes from `CH_FLAGGED` to `CH_QUIET` on any clear bit of the channel in a cycle with no event pulse. In every other case the state holds.

Each channel drives one registered interrupt request. It is the OR of the channel's four event flags, each gated by its own enable input.

Top module: `dma_irq_flags`

## Requirements
- R1: After reset the status word reads 0x0000_0000 and every interrupt request is 0.
- R2: Channel n owns status bits 5n to 5n+4: bit 5n is global, 5n+1 block end, 5n+2 half transfer, 5n+3 transfer complete, 5n+4 transfer error. An event pulse (evt_pulse bit 4n+k, k = 0 block end, 1 half, 2 complete, 3 error) sets its flag and the channel's global flag on the next clock edge. The status word is read at offset 0x124.
- R3: A bus write to offset 0x128 with a 1 in an event clear bit (same bit position as the flag) clears that event flag and the channel's global flag. The channel's other event flags are left unchanged.
- R4: A 1 in a channel's global clear bit (bit 5n at offset 0x128) clears the global flag and all four event flags of that channel.
- R5: Writing 0 to clear bits has no effect. Writes to the status offset and to unmapped offsets change no flag.
- R6: The clear word at 0x128 always reads 0, and any offset other than 0x124 and 0x128 reads 0.
- R7: If an event pulse and a clear of the same flag (event clear bit or global clear bit) arrive in the same cycle, the flag ends set. The global flag also ends set whenever any event of the channel fires in that cycle.
- R8: irq[n] is the OR over k of (event flag k of channel n AND irq_en bit 4n+k). It is registered, so it follows a flag change one clock later.
- R9: Bits 31:30 read as 0, and writing ones to them at offset 0x128 changes no flag.
- R10: A clear aimed at one channel leaves the flags of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 24 | Event pulses, bit 4n+k for channel n, event kind k |
| irq_en | input | 24 | Interrupt enables, same layout as evt_pulse |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 6 | Registered interrupt request per channel |

## Verification
The hardest case to reach is a single cycle in which one channel receives an event pulse and a clear write, because the outcome depends on which flag each side touches. The stimulus lines up the pulse and the write in the same cycle in three forms: the same event bit, the global clear bit, and a different event bit of the same channel. A second hard case is a channel whose global flag is 0 while an event flag stays 1. The stimulus reaches it by raising two events and then clearing only one of them, or by clearing an event flag that was never set. A reference model in the bench updates on every edge and is compared each cycle against the read data and the request lines.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int DEF_NCH    = 6;
    localparam int DEF_EVT_N  = 4;
    localparam int DEF_ADDR_W = 12;
    localparam int DEF_DATA_W = 32;

    typedef enum logic {
        CH_QUIET   = 1'b0,
        CH_FLAGGED = 1'b1
    } chan_state_e;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_STAT = 2'd1,
        RD_CLR  = 2'd2
    } rd_sel_e;

endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
    import dma_irq_pkg::*;
#(
    parameter int                ADDR_W   = DEF_ADDR_W,
    parameter int                DATA_W   = DEF_DATA_W,
    parameter int                STAT_W   = 30,
    parameter logic [ADDR_W-1:0] STAT_OFF = 'h124,
    parameter logic [ADDR_W-1:0] CLR_OFF  = 'h128
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [STAT_W-1:0] clr_vec,
    output rd_sel_e           rd_sel
);

    logic hit_clr;
    logic unused_rsv;

    assign hit_clr    = (bus_addr == CLR_OFF);
    assign unused_rsv = ^bus_wdata[DATA_W-1:STAT_W];

    always_comb begin
        clr_vec = '0;
        if (bus_wr && hit_clr) begin
            clr_vec = bus_wdata[STAT_W-1:0];
        end
    end

    always_comb begin
        rd_sel = RD_NONE;
        if (bus_addr == STAT_OFF) begin
            rd_sel = RD_STAT;
        end else if (hit_clr) begin
            rd_sel = RD_CLR;
        end
    end

endmodule

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
    import dma_irq_pkg::*;
#(
    parameter int EVT_N = DEF_EVT_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt,
    input  logic             glob_clr,
    input  logic [EVT_N-1:0] evt_clr,
    output logic             glob_flag,
    output logic [EVT_N-1:0] evt_flag
);

    chan_state_e      st_q, st_d;
    logic [EVT_N-1:0] flag_q, flag_d;
    logic             any_evt;
    logic             any_clr;

    assign any_evt = |evt;
    assign any_clr = glob_clr | (|evt_clr);

    // next state: RAISE on any event, DROP on any clear without event
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_QUIET:   if (any_evt) st_d = CH_FLAGGED;
            CH_FLAGGED: if (!any_evt && any_clr) st_d = CH_QUIET;
            default:    st_d = CH_QUIET;
        endcase
    end

    // per-event sticky flags, event beats clear
    for (genvar k = 0; k < EVT_N; k++) begin : g_flag
        assign flag_d[k] = evt[k] | (flag_q[k] & ~evt_clr[k] & ~glob_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CH_QUIET;
            flag_q <= '0;
        end else begin
            st_q   <= st_d;
            flag_q <= flag_d;
        end
    end

    // outputs
    always_comb begin
        glob_flag = (st_q == CH_FLAGGED);
        evt_flag  = flag_q;
    end

    for (genvar k = 0; k < EVT_N; k++) begin : g_chk
        assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt[k] |=> evt_flag[k]);
        assert_evt_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_clr[k] && !evt[k]) |=> !evt_flag[k]);
        assert_glob_wipe_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (glob_clr && !evt[k]) |=> !evt_flag[k]);
        assert_evt_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[k] && (evt_clr[k] || glob_clr)) |=> (evt_flag[k] && glob_flag));
    end

    assert_glob_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any_evt |=> glob_flag);
    assert_glob_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (any_clr && !any_evt) |=> !glob_flag);
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_evt && !any_clr) |=> ($stable(evt_flag) && $stable(glob_flag)));

endmodule

// File: rtl/dma_irq_req.sv
module dma_irq_req
    import dma_irq_pkg::*;
#(
    parameter int NCH   = DEF_NCH,
    parameter int EVT_N = DEF_EVT_N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH*EVT_N-1:0] evt_flags,
    input  logic [NCH*EVT_N-1:0] irq_en,
    output logic [NCH-1:0]       irq
);

    logic [NCH-1:0] req_d;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_req
        assign req_d[ch] = |(evt_flags[ch*EVT_N +: EVT_N] & irq_en[ch*EVT_N +: EVT_N]);

        assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[ch]) |-> $past(|evt_flags[ch*EVT_N +: EVT_N]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= '0;
        end else begin
            irq <= req_d;
        end
    end

endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
    import dma_irq_pkg::*;
#(
    parameter int                NCH      = DEF_NCH,
    parameter int                EVT_N    = DEF_EVT_N,
    parameter int                ADDR_W   = DEF_ADDR_W,
    parameter int                DATA_W   = DEF_DATA_W,
    parameter logic [ADDR_W-1:0] STAT_OFF = 'h124,
    parameter logic [ADDR_W-1:0] CLR_OFF  = 'h128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH*EVT_N-1:0] evt_pulse,
    input  logic [NCH*EVT_N-1:0] irq_en,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NCH-1:0]       irq
);

    localparam int GRP_W  = EVT_N + 1;
    localparam int STAT_W = NCH * GRP_W;

    logic [STAT_W-1:0]    clr_vec;
    logic [STAT_W-1:0]    stat_vec;
    logic [NCH-1:0]       glob_vec;
    logic [NCH*EVT_N-1:0] evt_vec;
    rd_sel_e              rd_sel;

    dma_irq_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .STAT_W  (STAT_W),
        .STAT_OFF(STAT_OFF),
        .CLR_OFF (CLR_OFF)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .clr_vec  (clr_vec),
        .rd_sel   (rd_sel)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dma_irq_chan #(.EVT_N(EVT_N)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt_pulse[ch*EVT_N +: EVT_N]),
            .glob_clr (clr_vec[ch*GRP_W]),
            .evt_clr  (clr_vec[ch*GRP_W+1 +: EVT_N]),
            .glob_flag(glob_vec[ch]),
            .evt_flag (evt_vec[ch*EVT_N +: EVT_N])
        );

        assign stat_vec[ch*GRP_W]           = glob_vec[ch];
        assign stat_vec[ch*GRP_W+1 +: EVT_N] = evt_vec[ch*EVT_N +: EVT_N];

        assert_chan_isolate_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[ch*GRP_W +: GRP_W] == '0 && evt_pulse[ch*EVT_N +: EVT_N] == '0)
            |=> $stable(stat_vec[ch*GRP_W +: GRP_W]));
    end

    always_comb begin
        bus_rdata = '0;
        unique case (rd_sel)
            RD_STAT: bus_rdata = DATA_W'(stat_vec);
            RD_CLR:  bus_rdata = '0;
            default: bus_rdata = '0;
        endcase
    end

    dma_irq_req #(.NCH(NCH), .EVT_N(EVT_N)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_flags(evt_vec),
        .irq_en   (irq_en),
        .irq      (irq)
    );

    assert_rsv_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:STAT_W] == '0);
    assert_clr_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == CLR_OFF) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_dma_irq_flags.sv
`timescale 1ns/1ps
module sim_dma_irq_flags;

    localparam logic [11:0] A_STAT = 12'h124;
    localparam logic [11:0] A_CLR  = 12'h128;
    localparam logic [11:0] A_NONE = 12'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] drv_evt = '0;
    logic [23:0] drv_en = '0;
    logic [11:0] drv_addr = A_STAT;
    logic        drv_wr = 1'b0;
    logic [31:0] drv_wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  irq;

    logic [29:0] ref_stat = '0;
    logic [5:0]  ref_irq = '0;
    int          n_tests = 0;
    int          n_fail = 0;
    string       cur_req = "R1";

    always #2.5 clk = ~clk;

    dma_irq_flags u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_pulse(drv_evt),
        .irq_en   (drv_en),
        .bus_addr (drv_addr),
        .bus_wr   (drv_wr),
        .bus_wdata(drv_wdata),
        .bus_rdata(rdata),
        .irq      (irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference model step, run at a rising edge with the driven inputs
    task automatic model_edge();
        logic [29:0] nx;
        logic [31:0] cw;
        logic [5:0]  ni;
        nx = ref_stat;
        cw = (drv_wr && drv_addr == A_CLR) ? drv_wdata : 32'h0;
        for (int n = 0; n < 6; n++) begin
            int  g;
            bit  anyev;
            bit  anyclr;
            g = 5 * n;
            ni[n] = 1'b0;
            for (int k = 0; k < 4; k++) begin
                if (ref_stat[g+1+k] && drv_en[4*n+k]) ni[n] = 1'b1;
            end
            anyev = 1'b0;
            anyclr = cw[g];
            for (int k = 0; k < 4; k++) begin
                if (drv_evt[4*n+k]) begin
                    nx[g+1+k] = 1'b1;
                    anyev = 1'b1;
                end else if (cw[g+1+k] || cw[g]) begin
                    nx[g+1+k] = 1'b0;
                end
                if (cw[g+1+k]) anyclr = 1'b1;
            end
            if (anyev) nx[g] = 1'b1;
            else if (anyclr) nx[g] = 1'b0;
        end
        ref_stat = nx;
        ref_irq = ni;
    endtask

    // one clock: model at the edge, compare at the falling edge
    task automatic tick();
        logic [31:0] exp_rd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp_rd = (drv_addr == A_STAT) ? {2'b00, ref_stat} : 32'h0;
        chk(cur_req, "model rdata", rdata, exp_rd);
        chk(cur_req, "model irq", {26'h0, irq}, {26'h0, ref_irq});
    endtask

    task automatic idle();
        drv_evt = '0; drv_wr = 1'b0; drv_addr = A_STAT; drv_wdata = '0;
    endtask

    task automatic pulse(input logic [23:0] ev);
        drv_evt = ev; tick(); idle();
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [23:0] ev);
        drv_addr = a; drv_wr = 1'b1; drv_wdata = d; drv_evt = ev; tick(); idle();
    endtask

    task automatic read_stat(input string req, input logic [31:0] exp);
        idle(); tick();
        chk(req, "status word", rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        chk("R1", "rdata in reset", rdata, 32'h0);
        rst_n = 1'b1;
        tick();
        chk("R1", "status after reset", rdata, 32'h0);
        chk("R1", "irq after reset", {26'h0, irq}, 32'h0);

        cur_req = "R2";
        pulse(24'h1 << 0);
        read_stat("R2", 32'h0000_0003);
        pulse(24'h1 << 23);
        pulse(24'h1 << 9);
        pulse(24'h1 << 14);
        read_stat("R2", 32'h2204_9403);

        cur_req = "R4";
        wr(A_CLR, 32'h3FFF_FFFF, '0);
        read_stat("R4", 32'h0);

        cur_req = "R3";
        pulse((24'h1 << 5) | (24'h1 << 6));
        read_stat("R3", 32'h0000_01A0);
        wr(A_CLR, 32'h0000_0100, '0);
        read_stat("R3", 32'h0000_0080);
        pulse(24'h1 << 12);
        wr(A_CLR, 32'h0002_0000, '0);
        read_stat("R3", 32'h0001_0080);

        cur_req = "R4";
        wr(A_CLR, 32'h0000_0020, '0);
        read_stat("R4", 32'h0001_0000);
        pulse(24'h00_F000);
        read_stat("R4", 32'h000F_8000);
        wr(A_CLR, 32'h0000_8000, '0);
        read_stat("R4", 32'h0);

        cur_req = "R5";
        pulse(24'h1 << 2);
        wr(A_STAT, 32'hFFFF_FFFF, '0);
        read_stat("R5", 32'h0000_0009);
        wr(A_CLR, 32'h0, '0);
        wr(A_NONE, 32'hFFFF_FFFF, '0);
        read_stat("R5", 32'h0000_0009);

        cur_req = "R6";
        drv_addr = A_CLR; tick();
        chk("R6", "clear word read", rdata, 32'h0);
        drv_addr = A_NONE; tick();
        chk("R6", "unmapped read", rdata, 32'h0);

        cur_req = "R9";
        wr(A_CLR, 32'hC000_0000, '0);
        read_stat("R9", 32'h0000_0009);
        chk("R9", "reserved bits", {30'h0, rdata[31:30]}, 32'h0);

        cur_req = "R10";
        pulse(24'h1 << 4);
        read_stat("R10", 32'h0000_0069);
        wr(A_CLR, 32'h0000_0001, '0);
        read_stat("R10", 32'h0000_0060);

        cur_req = "R7";
        wr(A_CLR, 32'h0080_0000, 24'h1 << 18);
        read_stat("R7", 32'h0090_0060);
        wr(A_CLR, 32'h0010_0000, 24'h1 << 16);
        read_stat("R7", 32'h0030_0060);
        wr(A_CLR, 32'h0020_0000, 24'h1 << 17);
        read_stat("R7", 32'h0050_0060);

        cur_req = "R8";
        chk("R8", "irq with enables off", {26'h0, irq}, 32'h0);
        drv_en = 24'h1 << 17;
        tick();
        chk("R8", "irq ch4 after enable", {26'h0, irq}, 32'h10);
        wr(A_CLR, 32'h0040_0000, '0);
        chk("R8", "irq lags flag clear", {26'h0, irq}, 32'h10);
        tick();
        chk("R8", "irq ch4 dropped", {26'h0, irq}, 32'h0);
        drv_en = 24'hFF_FFFF;
        tick();
        chk("R8", "irq ch1 all enables", {26'h0, irq}, 32'h02);
        drv_en = '0;
        repeat (2) tick();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule